// File: doc/BRIEF.md
# Hardware ticket lock

A shared mutual-exclusion lock for a fixed set of requesters that hands out ownership strictly in arrival order. Two counters are kept: a ticket dispenser that counts every accepted request, and a serving counter that counts every completed release. A requester pulses its acquire line and is given the current dispenser value as its ticket. The dispenser advances in the same step, so the fetch and the increment are one atomic action. The requester then owns the lock as soon as the serving counter equals its ticket. The owner pulses its release line, and the serving counter moves on by one, which passes the lock to the next ticket.

Several requesters may ask in the same cycle. Each gets a distinct ticket, handed out in ascending requester-index order, and the dispenser advances by the number of accepted requests. Waiters never change the serving counter; they only observe it, through their grant line and the exported serving value. Both counters wrap modulo 2^CW, with CW = clog2(NREQ)+1. At most NREQ tickets are ever outstanding, so the equality test stays correct across the wrap. A release from anyone but the holder changes nothing and raises an error pulse.

Top module: `ticket_mutex`

## Requirements
- R1: After reset, both counters read 0, no grant is asserted and `rel_err` is 0.
- R2: An acquire from a requester with no ticket, when no other ticket is outstanding, asserts that requester's grant in the cycle after the acquire edge.
- R3: Acquires that arrive in the same cycle receive consecutive tickets in ascending requester-index order (bit 0 first), so grants are given in that order.
- R4: Requests that arrive in different cycles are granted in arrival order (FIFO).
- R5: A release by the grant holder advances `serving` by exactly one after the edge. The grant then moves to the requester holding the next ticket, or to nobody if no such ticket is outstanding.
- R6: At most one grant bit is asserted in any cycle.
- R7: A release from a requester that does not hold the grant leaves `serving` and the grants unchanged. It asserts `rel_err` for exactly one cycle, in the cycle after the edge.
- R8: An acquire from a requester that already holds a ticket is ignored and consumes no ticket.
- R9: Both counters are CW bits wide and wrap modulo 2^CW (8 with NREQ=4). Granting continues in correct order across the wrap.
- R10: A holder keeps its grant until it releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq | input | NREQ | One-cycle acquire pulse per requester |
| rel | input | NREQ | One-cycle release pulse per requester |
| grant | output | NREQ | Lock ownership, one bit per requester |
| serving | output | CW | Current serving counter value |
| rel_err | output | 1 | One-cycle pulse after a release by a non-holder |

## Verification
The lock is driven with single acquires into an idle lock, with all four requesters asking in one cycle, and with requests staggered over several cycles in non-index order. Together these separate index-order tie breaking from true arrival order. One staggered run carries the counters through the wrap from 7 to 0, which exposes any comparison that is not modulo the counter width. Duplicate acquires and releases by non-holders are applied while another requester holds the lock. The grant and `serving` values afterwards show whether a ticket was wrongly consumed or the counter wrongly moved.

// File: rtl/ticket_mutex.sv
module ticket_mutex #(
  parameter int NREQ = 4,
  localparam int CW = $clog2(NREQ) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] acq,
  input  logic [NREQ-1:0] rel,
  output logic [NREQ-1:0] grant,
  output logic [CW-1:0]   serving,
  output logic            rel_err
);

  logic [CW-1:0]   next_tkt;
  logic [CW-1:0]   run;
  logic [CW-1:0]   tkt     [NREQ];
  logic [CW-1:0]   give    [NREQ];
  logic [NREQ-1:0] waiting;
  logic [NREQ-1:0] take;
  logic            good_rel;
  logic            bad_rel;

  assign take     = acq & ~waiting;
  assign good_rel = |(rel & grant);
  assign bad_rel  = |(rel & ~grant);

  for (genvar g = 0; g < NREQ; g++) begin : g_cmp
    assign grant[g] = waiting[g] && (tkt[g] == serving);
  end

  always_comb begin
    run = next_tkt;
    for (int i = 0; i < NREQ; i++) begin
      give[i] = run;
      if (take[i]) run = run + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_tkt <= '0;
      serving  <= '0;
      rel_err  <= 1'b0;
      waiting  <= '0;
      for (int i = 0; i < NREQ; i++) tkt[i] <= '0;
    end else begin
      next_tkt <= run;
      rel_err  <= bad_rel;
      if (good_rel) serving <= serving + CW'(1);
      for (int i = 0; i < NREQ; i++) begin
        if (take[i]) begin
          waiting[i] <= 1'b1;
          tkt[i]     <= give[i];
        end else if (rel[i] && grant[i]) begin
          waiting[i] <= 1'b0;
        end
      end
    end
  end

  a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r5_serve_step: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rel & grant)) |=> serving == $past(serving) + CW'(1));

  a_r7_serve_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(rel & grant)) |=> $stable(serving));

  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rel & ~grant)) |=> rel_err);

  a_r7_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(rel & ~grant)) |=> !rel_err);

  for (genvar g = 0; g < NREQ; g++) begin : g_hold
    a_r10_keep_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[g] && !rel[g]) |=> grant[g]);
  end

endmodule

// File: tb/tb_ticket_mutex.sv
module tb_ticket_mutex;
  localparam int NREQ = 4;
  localparam int CW = $clog2(NREQ) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREQ-1:0] acq = '0;
  logic [NREQ-1:0] rel = '0;
  logic [NREQ-1:0] grant;
  logic [CW-1:0]   serving;
  logic            rel_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ticket_mutex #(.NREQ(NREQ)) dut (
    .clk(clk), .rst_n(rst_n), .acq(acq), .rel(rel),
    .grant(grant), .serving(serving), .rel_err(rel_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [NREQ-1:0] a, input logic [NREQ-1:0] r);
    acq = a;
    rel = r;
    @(posedge clk);
    #1;
    acq = '0;
    rel = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 grant", grant, 0);
    chk("R1 serving", serving, 0);
    chk("R1 rel_err", rel_err, 0);
  endtask

  task automatic t_single();
    cyc(4'b0001, 4'b0000);
    chk("R2 grant", grant, 4'b0001);
    cyc(4'b0000, 4'b0000);
    cyc(4'b0000, 4'b0000);
    chk("R10 grant kept", grant, 4'b0001);
    cyc(4'b0000, 4'b0001);
    chk("R5 serving", serving, 1);
    chk("R5 grant gone", grant, 0);
  endtask

  task automatic t_simul();
    cyc(4'b1111, 4'b0000);
    chk("R3 first", grant, 4'b0001);
    chk("R6 onehot", $countones(grant), 1);
    cyc(4'b0000, 4'b0001);
    chk("R3 second", grant, 4'b0010);
    cyc(4'b0000, 4'b0010);
    chk("R3 third", grant, 4'b0100);
    cyc(4'b0000, 4'b0100);
    chk("R3 fourth", grant, 4'b1000);
    cyc(4'b0000, 4'b1000);
    chk("R5 empty", grant, 0);
    chk("R5 serving", serving, 5);
  endtask

  task automatic t_fifo_wrap();
    cyc(4'b1000, 4'b0000);
    cyc(4'b0010, 4'b0000);
    cyc(4'b0001, 4'b0000);
    chk("R4 first", grant, 4'b1000);
    cyc(4'b0000, 4'b1000);
    chk("R4 second", grant, 4'b0010);
    cyc(4'b0000, 4'b0010);
    chk("R4 third", grant, 4'b0001);
    chk("R4 serving", serving, 7);
    cyc(4'b0000, 4'b0001);
    chk("R9 wrap serving", serving, 0);
    chk("R9 idle", grant, 0);
    cyc(4'b0100, 4'b0000);
    chk("R9 grant after wrap", grant, 4'b0100);
    cyc(4'b0000, 4'b0100);
    chk("R9 serving after wrap", serving, 1);
  endtask

  task automatic t_bad_release();
    cyc(4'b0001, 4'b0000);
    cyc(4'b0000, 4'b0100);
    chk("R7 grant", grant, 4'b0001);
    chk("R7 serving", serving, 1);
    chk("R7 err set", rel_err, 1);
    cyc(4'b0000, 4'b0000);
    chk("R7 err clear", rel_err, 0);
  endtask

  task automatic t_dup();
    cyc(4'b0001, 4'b0000);
    cyc(4'b0010, 4'b0000);
    chk("R8 holder", grant, 4'b0001);
    cyc(4'b0000, 4'b0001);
    chk("R8 next ticket", grant, 4'b0010);
    chk("R8 serving", serving, 2);
    cyc(4'b0000, 4'b0010);
    chk("R8 done", grant, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_simul();
    t_fifo_wrap();
    t_bad_release();
    t_dup();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule